// File: doc/BRIEF.md
# Victim Line Buffer with Deferred Write-Back

This block is a small, fully associative store that sits between a write-back second-level cache and the memory bus. When the second-level cache throws out a line to make room for a fill, it hands the line to this buffer and reuses its own slot at once. It never waits for a memory write. A line that carries the modified flag is written to memory later, when the bus has nothing else to do.

While a line sits in the buffer it can still be found. A lookup that missed in the second-level cache is compared against every live entry in the same cycle. A hit returns the whole line and its modified flag with no wait state, and removes the entry so that the requester owns the line again.

With default parameters the buffer holds six 32-byte lines (192 bytes). Replacement prefers a free slot, then the oldest clean entry. When every slot holds modified data that has not been written back, the insert port refuses new lines until a memory write completes.

Top module: `vc_victim_buf`

## Requirements
- R1: After a synchronous reset no entry is live (every lookup misses), `wb_req` is 0 and `ins_ready` is 1.
- R2: A lookup (`lk_valid`=1) whose address equals a live entry's address raises `lk_hit` in the same cycle with that entry's line on `lk_data` and its modified flag on `lk_dirty`. The entry is removed at the clock edge, so a repeated lookup misses.
- R3: Up to `ENTRIES` distinct lines can be live at once, and each of them can be found by a lookup.
- R4: When every slot is occupied and a line arrives while a clean entry exists, the oldest clean entry (by insert order) is replaced. Modified entries are never replaced.
- R5: The write-back engine picks the oldest modified entry and asserts `wb_req` with its `wb_addr` and `wb_data`. These stay stable until a cycle with `wb_ack`=1. One cycle after the acknowledge `wb_req` is 0, and the entry is clean but still live.
- R6: When every slot is occupied by a modified entry, `ins_ready` is 0. It returns to 1 in the cycle after a write-back acknowledge cleans an entry.
- R7: A lookup hit on the entry whose write-back is in flight returns its data with `lk_dirty`=1 and does not cancel the request. The entry can no longer be found, but its slot stays occupied until the acknowledge frees it.
- R8: An insert whose address matches a live entry overwrites that entry's line, and the stored flag becomes the OR of the old and new modified flags. Only one entry per address ever exists.
- R9: Clean lines never cause a write-back request.
- R10: Asserting `rst` while a write-back is pending drops `wb_req` and invalidates every entry.
- R11: If the entry being written back is overwritten by an insert before the acknowledge, it stays modified after the acknowledge and is written back again with the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ins_valid | input | 1 | An evicted line is offered |
| ins_ready | output | 1 | The buffer can take a line this cycle |
| ins_addr | input | LINE_ADDR_W | Line address of the offered line |
| ins_data | input | LINE_BYTES*8 | Line contents |
| ins_dirty | input | 1 | The offered line is modified |
| lk_valid | input | 1 | A lookup is requested |
| lk_addr | input | LINE_ADDR_W | Line address to look up |
| lk_hit | output | 1 | The lookup found a live entry |
| lk_data | output | LINE_BYTES*8 | Line returned on a hit, zero otherwise |
| lk_dirty | output | 1 | Modified flag of the returned line |
| wb_req | output | 1 | Memory write request |
| wb_addr | output | LINE_ADDR_W | Line address of the write |
| wb_data | output | LINE_BYTES*8 | Line contents of the write |
| wb_ack | input | 1 | Memory accepted the write |

## Verification
The bench builds the buffer with `ENTRIES`=6, `LINE_ADDR_W`=8 and `LINE_BYTES`=4. Every slot can therefore be filled and emptied in a few cycles, and line contents can be computed from the address and a salt. Holding `wb_ack` low makes it possible to hold a write-back in flight for as long as needed. This brings within reach the full-and-all-modified stall, a hit on the in-flight entry, an overwrite during the flight, and reset while a request is pending. Insert order is varied so that the oldest-clean and oldest-modified choices can be observed at the ports.

// File: rtl/vc_pkg.sv
package vc_pkg;
   // keeps only the lowest set bit of a vector up to 32 bits wide
   function automatic logic [31:0] lowest_set(logic [31:0] v);
      return v & (~v + 32'd1);
   endfunction

   // index of the set bit of a one-hot vector (0 when empty)
   function automatic int unsigned oh_index(logic [31:0] v);
      int unsigned idx;
      idx = 0;
      for (int i = 0; i < 32; i++)
         if (v[i]) idx = idx | i;
      return idx;
   endfunction
endpackage

// File: rtl/vc_cam_match.sv
module vc_cam_match #(
   parameter int ENTRIES = 6,
   parameter int KEY_W   = 27
) (
   input  logic                 en,
   input  logic [KEY_W-1:0]     key,
   input  logic [KEY_W-1:0]     tags [ENTRIES],
   input  logic [ENTRIES-1:0]   live,
   output logic [ENTRIES-1:0]   hit_oh
);
   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      assign hit_oh[i] = en && live[i] && (tags[i] == key);
   end
endmodule

// File: rtl/vc_age_track.sv
module vc_age_track #(
   parameter int ENTRIES = 6
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic                            upd,
   input  logic [ENTRIES-1:0]              upd_oh,
   output logic [ENTRIES-1:0][ENTRIES-1:0] older
);
   // older[i][j] = 1 when slot i was written before slot j
   always_ff @(posedge clk) begin
      if (rst) begin
         older <= '0;
      end else if (upd) begin
         for (int k = 0; k < ENTRIES; k++) begin
            if (upd_oh[k]) begin
               for (int j = 0; j < ENTRIES; j++) begin
                  if (j != k) begin
                     older[k][j] <= 1'b0;
                     older[j][k] <= 1'b1;
                  end
               end
            end
         end
      end
   end

   a_r4_age_antisym: assert property (@(posedge clk) disable iff (rst)
      !(older[0][1] && older[1][0]));
endmodule

// File: rtl/vc_oldest_pick.sv
module vc_oldest_pick import vc_pkg::*; #(
   parameter int ENTRIES = 6
) (
   input  logic [ENTRIES-1:0][ENTRIES-1:0] older,
   input  logic [ENTRIES-1:0]              cand,
   output logic [ENTRIES-1:0]              pick_oh
);
   logic [ENTRIES-1:0] blocked;
   logic [ENTRIES-1:0] raw;

   always_comb begin
      for (int i = 0; i < ENTRIES; i++) begin
         blocked[i] = 1'b0;
         for (int j = 0; j < ENTRIES; j++)
            if (j != i && cand[j] && older[j][i]) blocked[i] = 1'b1;
         raw[i] = cand[i] && !blocked[i];
      end
      pick_oh = ENTRIES'(lowest_set(32'(raw)));
   end
endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf import vc_pkg::*; #(
   parameter int ENTRIES     = 6,
   parameter int LINE_ADDR_W = 27,
   parameter int LINE_BYTES  = 32,
   localparam int DATA_W     = LINE_BYTES * 8,
   localparam int IDX_W      = $clog2(ENTRIES)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   ins_valid,
   output logic                   ins_ready,
   input  logic [LINE_ADDR_W-1:0] ins_addr,
   input  logic [DATA_W-1:0]      ins_data,
   input  logic                   ins_dirty,
   input  logic                   lk_valid,
   input  logic [LINE_ADDR_W-1:0] lk_addr,
   output logic                   lk_hit,
   output logic [DATA_W-1:0]      lk_data,
   output logic                   lk_dirty,
   output logic                   wb_req,
   output logic [LINE_ADDR_W-1:0] wb_addr,
   output logic [DATA_W-1:0]      wb_data,
   input  logic                   wb_ack
);
   if (ENTRIES < 2 || ENTRIES > 32) begin : g_bad_entries
      $error("vc_victim_buf: ENTRIES must lie in 2..32");
   end
   if (LINE_BYTES < 1 || LINE_ADDR_W < 1) begin : g_bad_line
      $error("vc_victim_buf: line geometry must be positive");
   end

   // entry state
   logic [ENTRIES-1:0]     valid_q, dirty_q, gone_q;
   logic [LINE_ADDR_W-1:0] tag_q  [ENTRIES];
   logic [DATA_W-1:0]      line_q [ENTRIES];

   // write-back engine state
   logic                   wb_req_q, wb_stale_q;
   logic [IDX_W-1:0]       wb_idx_q;
   logic [LINE_ADDR_W-1:0] wb_addr_q;
   logic [DATA_W-1:0]      wb_data_q;

   logic [ENTRIES-1:0] visible, clean, free_v, free_oh;
   logic [ENTRIES-1:0] lk_oh, ins_oh, alloc_oh, old_clean_oh;
   logic [ENTRIES-1:0] wb_cand, old_dirty_oh;
   logic [ENTRIES-1:0][ENTRIES-1:0] older;
   logic               ins_do;
   logic [IDX_W-1:0]   pick_idx;

   assign visible = valid_q & ~gone_q;
   assign clean   = visible & ~dirty_q;
   assign free_v  = ~valid_q;
   assign free_oh = ENTRIES'(lowest_set(32'(free_v)));

   assign ins_ready = (|free_v) || (|clean);
   assign ins_do    = ins_valid && ins_ready;

   vc_cam_match #(.ENTRIES(ENTRIES), .KEY_W(LINE_ADDR_W)) u_lk_cam (
      .en(lk_valid), .key(lk_addr), .tags(tag_q), .live(visible), .hit_oh(lk_oh));

   vc_cam_match #(.ENTRIES(ENTRIES), .KEY_W(LINE_ADDR_W)) u_ins_cam (
      .en(ins_valid), .key(ins_addr), .tags(tag_q), .live(visible), .hit_oh(ins_oh));

   vc_age_track #(.ENTRIES(ENTRIES)) u_age (
      .clk(clk), .rst(rst), .upd(ins_do), .upd_oh(alloc_oh), .older(older));

   vc_oldest_pick #(.ENTRIES(ENTRIES)) u_pick_clean (
      .older(older), .cand(clean), .pick_oh(old_clean_oh));

   // slot choice: same address, then a free slot, then the oldest clean entry
   always_comb begin
      if (|ins_oh)      alloc_oh = ins_oh;
      else if (|free_v) alloc_oh = free_oh;
      else              alloc_oh = old_clean_oh;
   end

   // write-back candidates skip entries touched by this cycle's hit or insert
   assign wb_cand = visible & dirty_q & ~lk_oh & (ins_do ? ~alloc_oh : {ENTRIES{1'b1}});

   vc_oldest_pick #(.ENTRIES(ENTRIES)) u_pick_dirty (
      .older(older), .cand(wb_cand), .pick_oh(old_dirty_oh));

   assign pick_idx = IDX_W'(oh_index(32'(old_dirty_oh)));

   // lookup return path, zero wait
   always_comb begin
      lk_data  = '0;
      lk_dirty = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (lk_oh[i]) begin
            lk_data  = lk_data | line_q[i];
            lk_dirty = lk_dirty | dirty_q[i];
         end
      end
   end
   assign lk_hit = |lk_oh;

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q    <= '0;
         dirty_q    <= '0;
         gone_q     <= '0;
         wb_req_q   <= 1'b0;
         wb_stale_q <= 1'b0;
         wb_idx_q   <= '0;
      end else begin
         // write-back engine
         if (wb_req_q && wb_ack) begin
            wb_req_q <= 1'b0;
            if (!wb_stale_q) dirty_q[wb_idx_q] <= 1'b0;
            if (gone_q[wb_idx_q]) begin
               valid_q[wb_idx_q] <= 1'b0;
               gone_q[wb_idx_q]  <= 1'b0;
            end
         end else if (!wb_req_q && (|wb_cand)) begin
            wb_req_q   <= 1'b1;
            wb_stale_q <= 1'b0;
            wb_idx_q   <= pick_idx;
            wb_addr_q  <= tag_q[pick_idx];
            wb_data_q  <= line_q[pick_idx];
         end
         if (wb_req_q && !wb_ack && ins_do && alloc_oh[wb_idx_q])
            wb_stale_q <= 1'b1;

         // lookup hit hands the line back
         for (int i = 0; i < ENTRIES; i++) begin
            if (lk_oh[i]) begin
               if (wb_req_q && !wb_ack && wb_idx_q == IDX_W'(i)) gone_q[i] <= 1'b1;
               else                                               valid_q[i] <= 1'b0;
            end
         end

         // insert, last so it wins over a same-cycle release
         if (ins_do) begin
            for (int i = 0; i < ENTRIES; i++) begin
               if (alloc_oh[i]) begin
                  valid_q[i] <= 1'b1;
                  gone_q[i]  <= 1'b0;
                  dirty_q[i] <= ins_dirty | ((|ins_oh) & dirty_q[i]);
                  tag_q[i]   <= ins_addr;
                  line_q[i]  <= ins_data;
               end
            end
         end
      end
   end

   assign wb_req  = wb_req_q;
   assign wb_addr = wb_addr_q;
   assign wb_data = wb_data_q;

   // R5: request payload held until acknowledged
   a_r5_wb_hold: assert property (@(posedge clk) disable iff (rst)
      wb_req && !wb_ack |=> wb_req && $stable(wb_addr) && $stable(wb_data));

   // R5: acknowledge ends the request
   a_r5_ack_ends: assert property (@(posedge clk) disable iff (rst)
      wb_req && wb_ack |=> !wb_req);

   // R9: a request always targets a live, modified entry
   a_r9_wb_target_dirty: assert property (@(posedge clk) disable iff (rst)
      wb_req |-> valid_q[wb_idx_q] && dirty_q[wb_idx_q]);

   // R8: never two live entries with the lookup address
   a_r8_unique_tag: assert property (@(posedge clk) disable iff (rst)
      lk_valid |-> $countones(lk_oh) <= 1);

   // R7: a handed-back entry is only held for the write in flight
   a_r7_gone_pending: assert property (@(posedge clk) disable iff (rst)
      (|gone_q) |-> wb_req && gone_q[wb_idx_q] && $onehot0(gone_q));
endmodule

// File: tb/vc_victim_buf_tb.sv
module vc_victim_buf_tb;
   localparam int N  = 6;
   localparam int AW = 8;
   localparam int LB = 4;
   localparam int DW = LB * 8;

   logic          clk = 1'b0;
   logic          rst;
   logic          ins_valid, ins_ready, ins_dirty;
   logic [AW-1:0] ins_addr;
   logic [DW-1:0] ins_data;
   logic          lk_valid, lk_hit, lk_dirty;
   logic [AW-1:0] lk_addr;
   logic [DW-1:0] lk_data;
   logic          wb_req, wb_ack;
   logic [AW-1:0] wb_addr;
   logic [DW-1:0] wb_data;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   vc_victim_buf #(.ENTRIES(N), .LINE_ADDR_W(AW), .LINE_BYTES(LB)) u_dut (
      .clk(clk), .rst(rst),
      .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_addr(ins_addr),
      .ins_data(ins_data), .ins_dirty(ins_dirty),
      .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit),
      .lk_data(lk_data), .lk_dirty(lk_dirty),
      .wb_req(wb_req), .wb_addr(wb_addr), .wb_data(wb_data), .wb_ack(wb_ack));

   function automatic logic [DW-1:0] pat(int a, int salt);
      return DW'(a * 32'h01010101) ^ DW'(salt * 32'h1f2e3d4c);
   endfunction

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic ins(int a, bit d, int salt);
      ins_valid = 1'b1; ins_addr = AW'(a); ins_data = pat(a, salt); ins_dirty = d;
      @(posedge clk); @(negedge clk);
      ins_valid = 1'b0;
   endtask

   task automatic look(int a, bit exp_hit, bit exp_dirty, int salt, string req);
      lk_valid = 1'b1; lk_addr = AW'(a);
      #1;
      chk(lk_hit == exp_hit, req, "lk_hit", lk_hit, exp_hit);
      if (exp_hit) begin
         chk(lk_data == pat(a, salt), req, "lk_data", lk_data, pat(a, salt));
         chk(lk_dirty == exp_dirty, req, "lk_dirty", lk_dirty, exp_dirty);
      end
      @(posedge clk); @(negedge clk);
      lk_valid = 1'b0;
   endtask

   task automatic ack();
      wb_ack = 1'b1;
      @(posedge clk); @(negedge clk);
      wb_ack = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_wb(bit exp_req, int a, int salt, string req);
      #1;
      chk(wb_req == exp_req, req, "wb_req", wb_req, exp_req);
      if (exp_req) begin
         chk(wb_addr == AW'(a), req, "wb_addr", wb_addr, a);
         chk(wb_data == pat(a, salt), req, "wb_data", wb_data, pat(a, salt));
      end
   endtask

   task automatic chk_ready(bit exp, string req);
      #1;
      chk(ins_ready == exp, req, "ins_ready", ins_ready, exp);
   endtask

   initial begin
      #(8 * 200000);
      total++; bad++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst = 1'b1; ins_valid = 1'b0; ins_addr = '0; ins_data = '0; ins_dirty = 1'b0;
      lk_valid = 1'b0; lk_addr = '0; wb_ack = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;

      // R1 reset state
      chk_wb(1'b0, 0, 0, "R1");
      chk_ready(1'b1, "R1");
      look(5, 1'b0, 1'b0, 0, "R1");

      // R3 / R9 / R2: six clean lines, all found, none written back
      for (int a = 10; a < 16; a++) ins(a, 1'b0, 1);
      idle(3);
      chk_wb(1'b0, 0, 0, "R9");
      chk_ready(1'b1, "R3");
      for (int a = 10; a < 16; a++) look(a, 1'b1, 1'b0, 1, "R3");
      look(10, 1'b0, 1'b0, 1, "R2");

      // R4: oldest clean replaced
      for (int a = 20; a < 27; a++) ins(a, 1'b0, 2);
      look(20, 1'b0, 1'b0, 2, "R4");
      for (int a = 21; a < 27; a++) look(a, 1'b1, 1'b0, 2, "R4");

      // R4 / R5: older dirty entry kept, clean one replaced; write held until ack
      ins(30, 1'b1, 3);
      for (int a = 31; a < 37; a++) ins(a, 1'b0, 3);
      look(31, 1'b0, 1'b0, 3, "R4");
      for (int a = 32; a < 37; a++) look(a, 1'b1, 1'b0, 3, "R4");
      chk_wb(1'b1, 30, 3, "R5");
      idle(3);
      chk_wb(1'b1, 30, 3, "R5");
      ack();
      chk_wb(1'b0, 0, 0, "R5");
      look(30, 1'b1, 1'b0, 3, "R5");
      idle(2);
      chk_wb(1'b0, 0, 0, "R9");

      // R5: oldest dirty first
      for (int a = 40; a < 43; a++) ins(a, 1'b1, 4);
      chk_wb(1'b1, 40, 4, "R5");
      ack(); idle(1);
      chk_wb(1'b1, 41, 4, "R5");
      ack(); idle(1);
      chk_wb(1'b1, 42, 4, "R5");
      ack();
      for (int a = 40; a < 43; a++) look(a, 1'b1, 1'b0, 4, "R5");

      // R6: full of dirty lines stalls the insert port
      for (int a = 50; a < 56; a++) ins(a, 1'b1, 5);
      chk_ready(1'b0, "R6");
      chk_wb(1'b1, 50, 5, "R6");
      ack();
      chk_ready(1'b1, "R6");
      ins(56, 1'b0, 5);
      look(50, 1'b0, 1'b0, 5, "R6");

      // R7: hit on the in-flight entry
      chk_wb(1'b1, 51, 5, "R7");
      look(51, 1'b1, 1'b1, 5, "R7");
      look(51, 1'b0, 1'b0, 5, "R7");
      chk_wb(1'b1, 51, 5, "R7");
      look(56, 1'b1, 1'b0, 5, "R7");
      ins(57, 1'b1, 5);
      chk_ready(1'b0, "R7");
      ack();
      chk_ready(1'b1, "R7");
      chk_wb(1'b0, 0, 0, "R7");

      // R10: reset with a request pending
      idle(1);
      chk_wb(1'b1, 52, 5, "R10");
      rst = 1'b1;
      @(posedge clk); @(negedge clk);
      rst = 1'b0;
      chk_wb(1'b0, 0, 0, "R10");
      chk_ready(1'b1, "R10");
      look(52, 1'b0, 1'b0, 5, "R10");
      look(57, 1'b0, 1'b0, 5, "R10");

      // R11 / R8: overwrite during flight, flag merge, second write
      ins(60, 1'b1, 6);
      idle(1);
      ins(60, 1'b0, 7);
      chk_wb(1'b1, 60, 6, "R11");
      ack(); idle(1);
      chk_wb(1'b1, 60, 7, "R11");
      ack();
      look(60, 1'b1, 1'b0, 7, "R8");
      look(60, 1'b0, 1'b0, 7, "R8");

      // R8: clean overwrite leaves a single entry
      ins(61, 1'b0, 1);
      ins(61, 1'b0, 2);
      for (int a = 62; a < 67; a++) ins(a, 1'b0, 2);
      chk_ready(1'b1, "R8");
      look(61, 1'b1, 1'b0, 2, "R8");
      look(61, 1'b0, 1'b0, 2, "R8");
      for (int a = 62; a < 67; a++) look(a, 1'b1, 1'b0, 2, "R8");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule